// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Acknowledge Sequencer

The block pairs two eight-line priority interrupt units. The master takes global lines 0 to 7. The slave takes lines 8 to 15, and its request output feeds master line 2. One level output, `irq_out`, tells the processor that the master has a request that beats everything it has in service. When the processor pulses `ack_valid`, the block picks the winning source across both units and marks it in service in the right unit or units. One cycle later it returns an 8-bit vector and the global line number.

Software reaches the block through a byte-wide access port with these addresses:

| Address | Unit | Register |
|---|---|---|
| 0x20 | master | command |
| 0x21 | master | data |
| 0xA0 | slave | command |
| 0xA1 | slave | data |
| 0x4D0 | master | trigger mode |
| 0x4D1 | slave | trigger mode |

Each trigger-mode register has a fixed set of writable bits. The access and acknowledge inputs follow valid-only stream rules, with no ready signal. The block takes an access on every cycle in which `bus_valid` is high. A read answers on `rsp_valid`/`rsp_data` for exactly one cycle, in the cycle after the read. An acknowledge answers on `vec_valid`/`vec_data`/`vec_line` for exactly one cycle, in the cycle after the acknowledge. Neither response can be stalled, so the consumer must take it in that cycle.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `irq_out`, `rsp_valid` and `vec_valid` are low. The mask, pending, in-service and trigger-mode registers are all zero. Each unit's vector base is 0.
- R2: In edge mode, a low-to-high change on an unmasked line sets that line pending. `irq_out` is high from the cycle after the rising clock edge that samples the change.
- R3: A set trigger-mode bit makes its line level-sensitive: the pending bit follows the line level, and an acknowledge does not clear it. After an end-of-interrupt, a held line raises `irq_out` again.
- R4: Priority runs upward from the line after the rotation point, which is 0 at reset, so line 0 is highest by default. A pending line raises `irq_out` only if it outranks every in-service line. Command value 0xC0|n sets the lowest-priority line to n.
- R5: When the master wins on a line other than 2, an acknowledge marks that line in service and clears its pending bit in edge mode. It returns vector = master base + line, and global line = line.
- R6: When the slave has a winning request, master line 2 is set pending one cycle later. An acknowledge that the master wins on line 2 marks master line 2 and the slave's winner in service. It returns slave base + local line, and global line = local line + 8.
- R7: If the master wins on line 2 while the slave has no winner, the slave is treated as presenting line 7. The block returns slave base + 7 with global line 15, and marks only master line 2 in service.
- R8: An acknowledge while the master has no winner returns master base + 7 with global line 7, and changes no in-service bit.
- R9: Command byte 0x0B selects the in-service register for command-port reads. Command byte 0x0A selects the pending register. A data-port read returns the mask, and a data-port write in run state sets the mask.
- R10: Writes to the trigger-mode registers are ANDed with 0xF8 (master, 0x4D0) and 0xDE (slave, 0x4D1). Reads at those addresses return the stored value.
- R11: The block ignores an access with `bus_size` other than 0 (0 meaning one byte), and an access in the same cycle as `ack_valid`. It changes no register and gives no response. A read of an undecoded address returns 0x00.
- R12: Command byte 0x20 clears the highest-priority in-service bit. Command byte 0x60|n clears in-service bit n. Command byte 0xE0|n clears bit n and makes line n the lowest priority.
- R13: A command byte with bit 4 set starts initialisation, which clears the mask, pending, in-service and priority state. The next data byte sets the vector base from bits 7:3. One more data byte is skipped. If bit 0 of the initialisation byte was set, a further data byte follows, and its bit 1 enables auto end-of-interrupt (no in-service bit is kept on acknowledge).
- R14: `irq_out` follows the master's winner in the same cycle after every register write or acknowledge. For example, masking the only pending line drops it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; [7:0] master, [15:8] slave |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Port address |
| bus_size | input | 2 | Access size code; 0 = one byte |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 8 | Read response data |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_data | output | 8 | Returned vector |
| vec_line | output | 4 | Global line of the acknowledged source |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge path is tested with single requests on master lines, on slave lines and on line 7 itself. Together these separate a true line-7 request, a cascaded slave vector with its +8 line offset, and a plain master vector. Further tests pair two simultaneous requests under default and rotated priority, which shows whether the winner depends on the rotation point. Masking the slave after it has forwarded its request gives the spurious slave case. Acknowledging with nothing pending gives the spurious master case. A held level-mode line shows that an acknowledge leaves its pending bit in place where an edge-mode line loses it.

// File: rtl/cascade_intc_pkg.sv
package cascade_intc_pkg;

  localparam int UNIT_LINES = 8;
  localparam int LINE_W     = $clog2(UNIT_LINES);
  localparam logic [3:0] NO_RANK = 4'd8;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_SKIP,
    ST_MODE
  } init_step_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CMD,
    RD_DATA,
    RD_TRIG
  } rd_kind_e;

  // Rank of the best set bit in m when the scan starts just after the
  // rotation point; NO_RANK when m is empty.
  function automatic logic [3:0] rank_of(input logic [7:0] m,
                                         input logic [2:0] rot);
    logic [3:0] r;
    r = NO_RANK;
    for (int k = 7; k >= 0; k--) begin
      if (m[3'(k) + rot]) r = 4'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/intc_unit.sv
module intc_unit
  import cascade_intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] lvl_in,
  input  logic [7:0] pulse_in,
  input  logic [7:0] trig_mode,
  input  logic       cmd_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  input  logic       ack_take,
  input  logic [2:0] ack_line,
  output logic [7:0] irr_o,
  output logic [7:0] isr_o,
  output logic [7:0] imr_o,
  output logic       sel_isr_o,
  output logic [4:0] base_o,
  output logic       win_o,
  output logic [2:0] win_line_o
);

  logic [7:0] irr_q, isr_q, imr_q, last_q;
  logic [7:0] irr_n, isr_n, imr_n, last_n;
  logic [2:0] prio_q, prio_n;
  logic [4:0] base_q, base_n;
  logic       sel_isr_q, sel_isr_n;
  logic       aeoi_q, aeoi_n;
  logic       rot_aeoi_q, rot_aeoi_n;
  logic       need_mode_q, need_mode_n;
  init_step_e step_q, step_n;

  logic [3:0] req_rank, svc_rank;
  logic [2:0] eoi_line;

  assign req_rank   = rank_of(irr_q & ~imr_q, prio_q);
  assign svc_rank   = rank_of(isr_q, prio_q);
  assign win_o      = (req_rank < svc_rank);
  assign win_line_o = req_rank[2:0] + prio_q;
  assign eoi_line   = svc_rank[2:0] + prio_q;

  always_comb begin
    irr_n       = irr_q;
    isr_n       = isr_q;
    imr_n       = imr_q;
    last_n      = lvl_in;
    prio_n      = prio_q;
    base_n      = base_q;
    sel_isr_n   = sel_isr_q;
    aeoi_n      = aeoi_q;
    rot_aeoi_n  = rot_aeoi_q;
    need_mode_n = need_mode_q;
    step_n      = step_q;

    for (int i = 0; i < UNIT_LINES; i++) begin
      if (trig_mode[i]) irr_n[i] = lvl_in[i];
      else if (lvl_in[i] && !last_q[i]) irr_n[i] = 1'b1;
      if (pulse_in[i]) irr_n[i] = 1'b1;
    end

    if (ack_take) begin
      isr_n[ack_line] = 1'b1;
      if (aeoi_q) begin
        isr_n[ack_line] = 1'b0;
        if (rot_aeoi_q) prio_n = ack_line + 3'd1;
      end
      if (!trig_mode[ack_line]) irr_n[ack_line] = 1'b0;
    end else if (cmd_we) begin
      if (wdata[4]) begin
        irr_n       = '0;
        isr_n       = '0;
        imr_n       = '0;
        last_n      = '0;
        prio_n      = '0;
        base_n      = '0;
        sel_isr_n   = 1'b0;
        aeoi_n      = 1'b0;
        rot_aeoi_n  = 1'b0;
        need_mode_n = wdata[0];
        step_n      = ST_BASE;
      end else if (wdata[3]) begin
        if (wdata[1]) sel_isr_n = wdata[0];
      end else begin
        case (wdata[7:5])
          3'd0, 3'd4: rot_aeoi_n = wdata[7];
          3'd1, 3'd5: begin
            if (svc_rank != NO_RANK) begin
              isr_n[eoi_line] = 1'b0;
              if (wdata[7]) prio_n = eoi_line + 3'd1;
            end
          end
          3'd3: isr_n[wdata[2:0]] = 1'b0;
          3'd6: prio_n = wdata[2:0] + 3'd1;
          3'd7: begin
            isr_n[wdata[2:0]] = 1'b0;
            prio_n = wdata[2:0] + 3'd1;
          end
          default: ;
        endcase
      end
    end else if (data_we) begin
      case (step_q)
        ST_RUN:  imr_n = wdata;
        ST_BASE: begin
          base_n = wdata[7:3];
          step_n = ST_SKIP;
        end
        ST_SKIP: step_n = need_mode_q ? ST_MODE : ST_RUN;
        ST_MODE: begin
          aeoi_n = wdata[1];
          step_n = ST_RUN;
        end
        default: step_n = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q       <= '0;
      isr_q       <= '0;
      imr_q       <= '0;
      last_q      <= '0;
      prio_q      <= '0;
      base_q      <= '0;
      sel_isr_q   <= 1'b0;
      aeoi_q      <= 1'b0;
      rot_aeoi_q  <= 1'b0;
      need_mode_q <= 1'b0;
      step_q      <= ST_RUN;
    end else begin
      irr_q       <= irr_n;
      isr_q       <= isr_n;
      imr_q       <= imr_n;
      last_q      <= last_n;
      prio_q      <= prio_n;
      base_q      <= base_n;
      sel_isr_q   <= sel_isr_n;
      aeoi_q      <= aeoi_n;
      rot_aeoi_q  <= rot_aeoi_n;
      need_mode_q <= need_mode_n;
      step_q      <= step_n;
    end
  end

  assign irr_o     = irr_q;
  assign isr_o     = isr_q;
  assign imr_o     = imr_q;
  assign sel_isr_o = sel_isr_q;
  assign base_o    = base_q;

endmodule

// File: rtl/intc_bus_dec.sv
module intc_bus_dec
  import cascade_intc_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter logic [15:0] UNIT_PORT    = 16'h0020,
  parameter int          UNIT_SEL_BIT = 7,
  parameter logic [15:0] TRIG_PORT    = 16'h04D0
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              ack_valid,
  output logic [1:0]        cmd_we,
  output logic [1:0]        data_we,
  output logic [1:0]        trig_we,
  output logic              rd_en,
  output rd_kind_e          rd_kind,
  output logic              rd_unit
);

  localparam logic [ADDR_W-1:0] UNIT_DONT = ADDR_W'(1) | (ADDR_W'(1) << UNIT_SEL_BIT);
  localparam logic [ADDR_W-1:0] TRIG_DONT = ADDR_W'(1);

  logic acc_ok, hit_unit, hit_trig, unit_sel;

  assign acc_ok   = bus_valid && !ack_valid && (bus_size == 2'd0);
  assign hit_unit = (bus_addr & ~UNIT_DONT) == ADDR_W'(UNIT_PORT);
  assign hit_trig = (bus_addr & ~TRIG_DONT) == ADDR_W'(TRIG_PORT);
  assign unit_sel = hit_unit ? bus_addr[UNIT_SEL_BIT] : bus_addr[0];

  always_comb begin
    cmd_we  = '0;
    data_we = '0;
    trig_we = '0;
    rd_en   = acc_ok && !bus_write;
    rd_kind = RD_NONE;
    rd_unit = unit_sel;
    if (acc_ok) begin
      if (hit_unit) begin
        if (bus_write) begin
          if (bus_addr[0]) data_we[unit_sel] = 1'b1;
          else             cmd_we[unit_sel]  = 1'b1;
        end
        rd_kind = bus_addr[0] ? RD_DATA : RD_CMD;
      end else if (hit_trig) begin
        if (bus_write) trig_we[unit_sel] = 1'b1;
        rd_kind = RD_TRIG;
      end
    end
  end

endmodule

// File: rtl/intc_ack_sel.sv
module intc_ack_sel #(
  parameter int CASCADE_LINE = 2
) (
  input  logic       m_win,
  input  logic [2:0] m_line,
  input  logic [4:0] m_base,
  input  logic       s_win,
  input  logic [2:0] s_line,
  input  logic [4:0] s_base,
  output logic       m_take,
  output logic       s_take,
  output logic [7:0] vec,
  output logic [3:0] gline
);

  localparam logic [2:0] SPUR_LINE = 3'd7;

  always_comb begin
    m_take = 1'b0;
    s_take = 1'b0;
    vec    = {m_base, SPUR_LINE};
    gline  = {1'b0, SPUR_LINE};
    if (m_win) begin
      m_take = 1'b1;
      if (m_line != 3'(CASCADE_LINE)) begin
        vec   = {m_base, m_line};
        gline = {1'b0, m_line};
      end else if (s_win) begin
        s_take = 1'b1;
        vec    = {s_base, s_line};
        gline  = {1'b1, s_line};
      end else begin
        vec   = {s_base, SPUR_LINE};
        gline = {1'b1, SPUR_LINE};
      end
    end
  end

endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cascade_intc_pkg::*;
#(
  parameter int         ADDR_W        = 16,
  parameter int         CASCADE_LINE  = 2,
  parameter logic [7:0] MST_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SLV_TRIG_MASK = 8'hDE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       irq_in,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [7:0]        bus_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  input  logic              ack_valid,
  output logic              vec_valid,
  output logic [7:0]        vec_data,
  output logic [3:0]        vec_line,
  output logic              irq_out
);

  localparam int UNITS = 2;

  logic [1:0] cmd_we, data_we, trig_we, take;
  logic       rd_en, rd_unit;
  rd_kind_e   rd_kind;

  logic [7:0] irr_w  [UNITS];
  logic [7:0] isr_w  [UNITS];
  logic [7:0] imr_w  [UNITS];
  logic [7:0] trig_q [UNITS];
  logic       sel_w  [UNITS];
  logic [4:0] base_w [UNITS];
  logic       win_w  [UNITS];
  logic [2:0] line_w [UNITS];

  logic [7:0] ack_vec;
  logic [3:0] ack_gline;
  logic       m_take, s_take;
  logic [7:0] rd_mux;

  intc_bus_dec #(
    .ADDR_W (ADDR_W)
  ) u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .ack_valid (ack_valid),
    .cmd_we    (cmd_we),
    .data_we   (data_we),
    .trig_we   (trig_we),
    .rd_en     (rd_en),
    .rd_kind   (rd_kind),
    .rd_unit   (rd_unit)
  );

  intc_ack_sel #(
    .CASCADE_LINE (CASCADE_LINE)
  ) u_ack (
    .m_win  (win_w[0]),
    .m_line (line_w[0]),
    .m_base (base_w[0]),
    .s_win  (win_w[1]),
    .s_line (line_w[1]),
    .s_base (base_w[1]),
    .m_take (m_take),
    .s_take (s_take),
    .vec    (ack_vec),
    .gline  (ack_gline)
  );

  assign take = {ack_valid && s_take, ack_valid && m_take};

  for (genvar gi = 0; gi < UNITS; gi++) begin : g_unit
    localparam logic [7:0] WMASK = (gi == 0) ? MST_TRIG_MASK : SLV_TRIG_MASK;
    logic [7:0] pulse;

    if (gi == 0) begin : g_mst
      assign pulse = 8'(win_w[1]) << CASCADE_LINE;
    end else begin : g_slv
      assign pulse = '0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          trig_q[gi] <= '0;
      else if (trig_we[gi]) trig_q[gi] <= bus_wdata & WMASK;
    end

    intc_unit u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_in     (irq_in[gi*8 +: 8]),
      .pulse_in   (pulse),
      .trig_mode  (trig_q[gi]),
      .cmd_we     (cmd_we[gi]),
      .data_we    (data_we[gi]),
      .wdata      (bus_wdata),
      .ack_take   (take[gi]),
      .ack_line   (line_w[gi]),
      .irr_o      (irr_w[gi]),
      .isr_o      (isr_w[gi]),
      .imr_o      (imr_w[gi]),
      .sel_isr_o  (sel_w[gi]),
      .base_o     (base_w[gi]),
      .win_o      (win_w[gi]),
      .win_line_o (line_w[gi])
    );
  end

  always_comb begin
    case (rd_kind)
      RD_CMD:  rd_mux = sel_w[rd_unit] ? isr_w[rd_unit] : irr_w[rd_unit];
      RD_DATA: rd_mux = imr_w[rd_unit];
      RD_TRIG: rd_mux = trig_q[rd_unit];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
      vec_line  <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_data  <= rd_en ? rd_mux : 8'h00;
      vec_valid <= ack_valid;
      if (ack_valid) begin
        vec_data <= ack_vec;
        vec_line <= ack_gline;
      end
    end
  end

  assign irq_out = win_w[0];

endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
  parameter int         ADDR_W        = 16,
  parameter logic [7:0] MST_TRIG_MASK = 8'hF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              ack_valid,
  input logic              rsp_valid,
  input logic [7:0]        rsp_data,
  input logic              vec_valid,
  input logic [7:0]        vec_data,
  input logic [3:0]        vec_line
);

  // R5
  vec_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_data[2:0] == vec_line[2:0]);

  // R8
  vec_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_valid));

  // R11
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write && !ack_valid && bus_size == 2'd0));

  // R11
  size_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_size != 2'd0) |=> !rsp_valid);

  // R10
  trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(bus_addr) == ADDR_W'(16'h04D0)) |-> (rsp_data & ~MST_TRIG_MASK) == 8'h00);

endmodule

bind cascade_intc cascade_intc_chk #(
  .ADDR_W        (ADDR_W),
  .MST_TRIG_MASK (MST_TRIG_MASK)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .ack_valid (ack_valid),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .vec_valid (vec_valid),
  .vec_data  (vec_data),
  .vec_line  (vec_line)
);

// File: tb/cascade_intc_tb_top.sv
`timescale 1ns/1ps
module cascade_intc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [7:0]  bus_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        ack_valid = 1'b0;
  logic        vec_valid;
  logic [7:0]  vec_data;
  logic [3:0]  vec_line;
  logic        irq_out;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  // {line[3:0], expected vector[7:0]} with master base 0x40, slave base 0x70
  localparam logic [11:0] VEC_TBL [6] = '{12'h040, 12'h343, 12'h747,
                                          12'h971, 12'hF77, 12'hC74};

  always #5 clk = ~clk;

  cascade_intc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .ack_valid (ack_valid),
    .vec_valid (vec_valid),
    .vec_data  (vec_data),
    .vec_line  (vec_line),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d, output logic v,
                        input logic [1:0] sz = 2'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_valid = 1'b0; bus_size = 2'd0;
    d = rsp_data; v = rsp_valid;
  endtask

  task automatic do_ack(output logic [7:0] v, output logic [3:0] l, output logic ok);
    @(negedge clk);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    v = vec_data; l = vec_line; ok = vec_valid;
  endtask

  task automatic rd_isr(input logic [15:0] cmd_port, output logic [7:0] d);
    logic v;
    bus_wr(cmd_port, 8'h0B);
    bus_rd(cmd_port, d, v);
    bus_wr(cmd_port, 8'h0A);
  endtask

  task automatic do_init(input logic [7:0] m_mode);
    bus_wr(16'h0020, 8'h11); bus_wr(16'h0021, 8'h40);
    bus_wr(16'h0021, 8'h04); bus_wr(16'h0021, m_mode);
    bus_wr(16'h00A0, 8'h11); bus_wr(16'h00A1, 8'h70);
    bus_wr(16'h00A1, 8'h02); bus_wr(16'h00A1, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v8;
    logic [3:0] ln;
    logic       ok;

    idle(4);
    // R1 reset state
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'h00);
    chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
    rst_n = 1'b1;
    idle(1);
    bus_rd(16'h0021, d, ok);
    chk("R1 mask after reset", d, 8'h00);
    chk("R9 read response valid", {7'd0, ok}, 8'h01);
    bus_rd(16'h04D1, d, ok);
    chk("R1 slave trigger after reset", d, 8'h00);
    do_ack(v8, ln, ok);
    chk("R1 base zero spurious vector", v8, 8'h07);

    do_init(8'h01);

    // Table walk: R2, R5, R6
    for (int t = 0; t < 6; t++) begin
      logic [3:0] line;
      line = VEC_TBL[t][11:8];
      irq_in[line] = 1'b1;
      idle(3);
      chk($sformatf("R2 irq_out line %0d", line), {7'd0, irq_out}, 8'h01);
      do_ack(v8, ln, ok);
      chk($sformatf("R5/R6 vector line %0d", line), v8, VEC_TBL[t][7:0]);
      chk($sformatf("R6 global line %0d", line), {4'd0, ln}, {4'd0, line});
      if (line >= 4'd8) bus_wr(16'h00A0, 8'h20);
      bus_wr(16'h0020, 8'h20);
      irq_in[line] = 1'b0;
      idle(3);
      chk($sformatf("R14 irq_out clear line %0d", line), {7'd0, irq_out}, 8'h00);
    end

    // R8 spurious master
    do_ack(v8, ln, ok);
    chk("R8 spurious master vector", v8, 8'h47);
    chk("R8 spurious master line", {4'd0, ln}, 8'h07);
    rd_isr(16'h0020, d);
    chk("R8 in-service unchanged", d, 8'h00);

    // R7 spurious slave
    irq_in[9] = 1'b1;
    idle(3);
    bus_wr(16'h00A1, 8'h02);
    idle(2);
    chk("R7 irq_out still high", {7'd0, irq_out}, 8'h01);
    do_ack(v8, ln, ok);
    chk("R7 spurious slave vector", v8, 8'h77);
    chk("R7 spurious slave line", {4'd0, ln}, 8'h0F);
    rd_isr(16'h0020, d);
    chk("R7 master line 2 in service", d, 8'h04);
    rd_isr(16'h00A0, d);
    chk("R7 slave nothing in service", d, 8'h00);
    irq_in[9] = 1'b0;
    idle(2);
    do_init(8'h01);

    // R10 trigger masks, R3 level mode
    bus_wr(16'h04D0, 8'hFF);
    bus_rd(16'h04D0, d, ok);
    chk("R10 master trigger mask", d, 8'hF8);
    bus_wr(16'h04D1, 8'hFF);
    bus_rd(16'h04D1, d, ok);
    chk("R10 slave trigger mask", d, 8'hDE);
    bus_wr(16'h04D1, 8'h00);
    irq_in[3] = 1'b1;
    idle(2);
    do_ack(v8, ln, ok);
    chk("R3 level vector", v8, 8'h43);
    bus_rd(16'h0020, d, ok);
    chk("R3 level pending kept after ack", d, 8'h08);
    bus_wr(16'h0020, 8'h20);
    chk("R3 level re-raises irq_out", {7'd0, irq_out}, 8'h01);
    irq_in[3] = 1'b0;
    idle(2);
    chk("R3 level drop clears", {7'd0, irq_out}, 8'h00);
    bus_wr(16'h04D0, 8'h00);

    // R4 priority
    irq_in[1] = 1'b1; irq_in[4] = 1'b1;
    idle(2);
    do_ack(v8, ln, ok);
    chk("R4 default priority", v8, 8'h41);
    chk("R4 lower line blocked by in-service", {7'd0, irq_out}, 8'h00);
    bus_wr(16'h0020, 8'h20);
    chk("R12 nonspecific EOI releases", {7'd0, irq_out}, 8'h01);
    do_ack(v8, ln, ok);
    chk("R4 second vector", v8, 8'h44);
    bus_wr(16'h0020, 8'h20);
    irq_in[1] = 1'b0; irq_in[4] = 1'b0;
    bus_wr(16'h0020, 8'hC3);
    irq_in[1] = 1'b1; irq_in[5] = 1'b1;
    idle(2);
    do_ack(v8, ln, ok);
    chk("R4 rotated priority", v8, 8'h45);
    bus_wr(16'h0020, 8'h20);
    do_ack(v8, ln, ok);
    chk("R4 rotated second", v8, 8'h41);
    bus_wr(16'h0020, 8'h20);
    irq_in[1] = 1'b0; irq_in[5] = 1'b0;
    bus_wr(16'h0020, 8'hC7);

    // R12 specific EOI
    irq_in[6] = 1'b1;
    idle(2);
    do_ack(v8, ln, ok);
    chk("R12 vector", v8, 8'h46);
    rd_isr(16'h0020, d);
    chk("R12 in service before EOI", d, 8'h40);
    bus_wr(16'h0020, 8'h66);
    rd_isr(16'h0020, d);
    chk("R12 specific EOI clears", d, 8'h00);
    irq_in[6] = 1'b0;

    // R14 mask updates irq_out
    irq_in[0] = 1'b1;
    idle(2);
    bus_wr(16'h0021, 8'h01);
    chk("R14 masked drops irq_out", {7'd0, irq_out}, 8'h00);
    bus_wr(16'h0021, 8'h00);
    chk("R14 unmask raises irq_out", {7'd0, irq_out}, 8'h01);
    do_ack(v8, ln, ok);
    bus_wr(16'h0020, 8'h20);
    irq_in[0] = 1'b0;

    // R11 ignored accesses
    bus_wr(16'h0021, 8'hFF, 2'd1);
    bus_rd(16'h0021, d, ok);
    chk("R11 wide write ignored", d, 8'h00);
    bus_rd(16'h0021, d, ok, 2'd2);
    chk("R11 wide read no response", {7'd0, ok}, 8'h00);
    bus_rd(16'h0030, d, ok);
    chk("R11 undecoded read", d, 8'h00);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'h0021; bus_wdata = 8'hFF;
    ack_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; ack_valid = 1'b0;
    chk("R11 ack still served", vec_data, 8'h47);
    bus_rd(16'h0021, d, ok);
    chk("R11 write with ack dropped", d, 8'h00);

    // R13 init clears and auto-EOI
    bus_wr(16'h0021, 8'h55);
    bus_rd(16'h0021, d, ok);
    chk("R9 mask readback", d, 8'h55);
    do_init(8'h03);
    bus_rd(16'h0021, d, ok);
    chk("R13 init clears mask", d, 8'h00);
    irq_in[0] = 1'b1;
    idle(2);
    do_ack(v8, ln, ok);
    chk("R13 auto-EOI vector", v8, 8'h40);
    rd_isr(16'h0020, d);
    chk("R13 auto-EOI keeps no in-service", d, 8'h00);
    irq_in[0] = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule